// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial control-port slave. It gives an external host read and write access to a bank of 32 configuration registers, each 8 bits wide. The host pulls the active-low select `csN` low and toggles `sclk`. It sends one instruction byte and then between one and four data bytes. Input bits are taken on rising `sclk` edges. Read data is launched on falling `sclk` edges, so the host can capture each bit on the following rising edge. The block samples `csN`, `sclk` and `sdioIn` with the chip's own clock `clk` through a short synchronizer, so `sclk` must run well below `clk`.

Register 0 holds the port's mode bits. Bit 0 selects least-significant-bit-first order. Bit 1 sends read data to the separate `sdoOut` pin instead of the shared data pin. Both bits are captured when `csN` falls, so writing register 0 changes the mode from the next transaction onwards. Every register is presented in parallel on `cfgRegs` for the rest of the chip. The pad tristate buffers are outside this block; the port exposes an output-enable signal for each data pin.

Top module: `spi_regs_port`

## Requirements
- R1: In MSB-first order, the instruction byte has bit 7 as the read flag (1 = read, 0 = write), bits 6:5 as the byte count field, and bits 4:0 as the starting register address. Its bits are taken on rising `sclk` edges while `csN` is low.
- R2: For a write, each group of eight rising edges after the instruction forms one byte for the current address. A register changes only once all eight of its bits have arrived.
- R3: For a read, the current register's bits appear on the data output one bit per falling `sclk` edge, starting with the falling edge after the instruction's last bit. In MSB-first order, bit 7 comes first.
- R4: The byte count field encodes the count minus one, so a transfer carries 1 to 4 bytes. After the last byte, further `sclk` edges change nothing until `csN` rises.
- R5: After each byte the address moves to the next register. It steps down in MSB-first order and up in LSB-first order, and wraps modulo 32 in both directions.
- R6: When register 0 bit 0 is 1 at the falling edge of `csN`, the instruction byte and all data bytes of that transaction move least significant bit first. The field positions of R1 are unchanged.
- R7: When register 0 bit 1 is 0, read data uses `sdioOut` with `sdioOe` high, and `sdoOe` stays low. When bit 1 is 1, read data uses `sdoOut` with `sdoOe` high, and `sdioOe` stays low. Each enable is high only during the data phase of a read.
- R8: If `csN` rises before a data byte is complete, the transaction ends and that partial byte is dropped; no register changes.
- R9: After reset, all registers read 0 and both output enables are low.
- R10: `cfgRegs[8*i+7:8*i]` always shows register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock that samples the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdioIn | input | 1 | Input side of the shared data pin |
| sdioOut | output | 1 | Read data toward the shared data pin |
| sdioOe | output | 1 | Drive enable for the shared data pin |
| sdoOut | output | 1 | Read data toward the separate output pin |
| sdoOe | output | 1 | Drive enable for the separate output pin |
| cfgRegs | output | 256 | All 32 registers in parallel, register i in bits 8*i+7:8*i |

## Verification
The assertions check, on every cycle, these properties:
- A rise of `csN` returns the control to idle.
- The bit counter moves only on a rising serial edge.
- No register changes except on a completed write byte.
- The read output bit changes only on a falling serial edge.
- The address takes exactly one step in the direction set by the latched order after each byte.

Other behaviours can only be shown by the bench's transactions:
- the byte contents arriving in the right bit order;
- the wrap of bursts past addresses 0 and 31;
- ignoring surplus bytes;
- dropping a cut-off byte;
- a mode change taking effect only at the next transaction;
- the choice of output pin.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  // Register 0 carries the port's own mode bits
  localparam int MODE_REG = 0;
  localparam int LSB_BIT  = 0;
  localparam int FOUR_BIT = 1;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR,
    PH_DATA,
    PH_DONE
  } phase_t;

  // Strobes from control to datapath, one cycle wide unless noted
  typedef struct packed {
    logic start;      // csN fell
    logic shiftIn;    // rising sclk inside header or data
    logic bitVal;     // synchronized input bit
    logic hdrDone;    // last header bit arrives now
    logic byteDone;   // last bit of a data byte arrives now
    logic wrCommit;   // byteDone of a write
    logic shiftOut;   // falling sclk during read data phase
    logic readPhase;  // level: read data phase active
  } strobe_t;

endpackage

// File: rtl/spi_regs_ctrl.sv
module spi_regs_ctrl
  import spi_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdioIn,
  input  logic             hdrRnw,
  input  logic [CNT_W-1:0] hdrCount,
  output strobe_t          stb
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  // synchronizer chain: {sdi, sclk, cs}
  logic [2:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= 3'b001;
    end else begin
      syncQ[0] <= {sdioIn, sclk, csN};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  logic csS, sclkS, sdiS;
  assign csS   = syncQ[SYNC_STAGES-1][0];
  assign sclkS = syncQ[SYNC_STAGES-1][1];
  assign sdiS  = syncQ[SYNC_STAGES-1][2];

  logic csD, sclkD;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD   <= 1'b1;
      sclkD <= 1'b0;
    end else begin
      csD   <= csS;
      sclkD <= sclkS;
    end
  end

  logic csFall, csRise, sRise, sFall;
  assign csFall = csD & ~csS;
  assign csRise = ~csD & csS;
  assign sRise  = ~sclkD & sclkS & ~csS;
  assign sFall  = sclkD & ~sclkS & ~csS;

  phase_t           phase;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bytesLeft;
  logic             rnwQ;
  logic             lastBit;

  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    stb           = '0;
    stb.start     = csFall;
    stb.bitVal    = sdiS;
    stb.shiftIn   = sRise && (phase == PH_HDR || phase == PH_DATA);
    stb.hdrDone   = sRise && phase == PH_HDR && lastBit;
    stb.byteDone  = sRise && phase == PH_DATA && lastBit;
    stb.wrCommit  = stb.byteDone && !rnwQ;
    stb.shiftOut  = sFall && phase == PH_DATA && rnwQ;
    stb.readPhase = (phase == PH_DATA) && rnwQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      bytesLeft <= '0;
      rnwQ      <= 1'b0;
    end else if (csS) begin
      phase <= PH_IDLE;                       // R8: select released ends all
    end else if (csFall) begin
      phase  <= PH_HDR;
      bitCnt <= '0;
    end else if (sRise) begin
      case (phase)
        PH_HDR: begin
          if (lastBit) begin
            phase     <= PH_DATA;
            bitCnt    <= '0;
            bytesLeft <= hdrCount;            // R4: count minus one
            rnwQ      <= hdrRnw;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (lastBit) begin
            bitCnt <= '0;
            if (bytesLeft == '0) phase <= PH_DONE;   // R4: surplus ignored
            else bytesLeft <= bytesLeft - 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: a rise of the select always lands the control in idle
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> phase == PH_IDLE);

  // R2: bits are counted only on rising serial edges
  a_r2_count_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!sRise && !csFall) |=> $stable(bitCnt));

endmodule

// File: rtl/spi_regs_dpath.sv
module spi_regs_dpath
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         stb,
  output logic                            hdrRnw,
  output logic [CNT_W-1:0]                hdrCount,
  output logic                            outBit,
  output logic                            sdioOe,
  output logic                            sdoOe,
  output logic [(DATA_W<<ADDR_W)-1:0]     cfgRegs
);

  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] shiftQ, shiftNext, rdQ;
  logic [ADDR_W-1:0] addrQ, addrStep, hdrAddr;
  logic              lsbQ, fourQ, outBitQ;
  logic [DATA_W-1:0] regArr [NUM_REGS];

  // R6: insertion side follows the latched order
  assign shiftNext = lsbQ ? {stb.bitVal, shiftQ[DATA_W-1:1]}
                          : {shiftQ[DATA_W-2:0], stb.bitVal};

  // R1: instruction fields
  assign hdrRnw   = shiftNext[DATA_W-1];
  assign hdrCount = shiftNext[DATA_W-2 -: CNT_W];
  assign hdrAddr  = shiftNext[ADDR_W-1:0];

  // R5: step direction follows the order, wraps naturally
  assign addrStep = lsbQ ? addrQ + 1'b1 : addrQ - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      rdQ     <= '0;
      addrQ   <= '0;
      lsbQ    <= 1'b0;
      fourQ   <= 1'b0;
      outBitQ <= 1'b0;
    end else begin
      if (stb.start) begin
        lsbQ  <= regArr[MODE_REG][LSB_BIT];
        fourQ <= regArr[MODE_REG][FOUR_BIT];
      end
      if (stb.shiftIn) shiftQ <= shiftNext;
      if (stb.hdrDone) begin
        addrQ <= hdrAddr;
        rdQ   <= regArr[hdrAddr];
      end
      if (stb.byteDone) begin
        addrQ <= addrStep;
        rdQ   <= regArr[addrStep];
      end
      if (stb.shiftOut) begin           // R3: launch on falling edge
        outBitQ <= lsbQ ? rdQ[0] : rdQ[DATA_W-1];
        rdQ     <= lsbQ ? (rdQ >> 1) : (rdQ << 1);
      end
    end
  end

  // Register bank, R2 and R10
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (stb.wrCommit && addrQ == ADDR_W'(i)) q <= shiftNext;
    end
    assign regArr[i] = q;
    assign cfgRegs[i*DATA_W +: DATA_W] = q;
  end

  // R7: pin choice
  assign outBit = outBitQ;
  assign sdioOe = stb.readPhase & ~fourQ;
  assign sdoOe  = stb.readPhase & fourQ;

  // R2: the bank only moves on a completed write byte
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCommit |=> $stable(cfgRegs));

  // R5: one address step per byte, in the latched direction
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.byteDone |=> addrQ == ($past(lsbQ) ? $past(addrQ) + ADDR_W'(1)
                                           : $past(addrQ) - ADDR_W'(1)));

  // R3: the read bit moves only on falling serial edges
  a_r3_launch_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shiftOut |=> $stable(outBitQ));

endmodule

// File: rtl/spi_regs_port.sv
module spi_regs_port
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        csN,
  input  logic                        sclk,
  input  logic                        sdioIn,
  output logic                        sdioOut,
  output logic                        sdioOe,
  output logic                        sdoOut,
  output logic                        sdoOe,
  output logic [(DATA_W<<ADDR_W)-1:0] cfgRegs
);

  strobe_t          stb;
  logic             hdrRnw;
  logic [CNT_W-1:0] hdrCount;
  logic             outBit;

  spi_regs_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .hdrRnw(hdrRnw), .hdrCount(hdrCount), .stb(stb)
  );

  spi_regs_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hdrRnw(hdrRnw), .hdrCount(hdrCount),
    .outBit(outBit), .sdioOe(sdioOe), .sdoOe(sdoOe), .cfgRegs(cfgRegs)
  );

  assign sdioOut = outBit;
  assign sdoOut  = outBit;

endmodule

// File: tb/test_spi_regs_port.sv
`timescale 1ns/1ps
module test_spi_regs_port;

  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [255:0] cfgRegs;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] model [32];
  logic [7:0] expQ [$];
  bit monOn = 0, monFour = 0, monLsb = 0;
  string monTag = "";
  int monCnt = 0;
  logic [7:0] monByte = '0;
  bit monOeBad = 0;

  always #2.5 clk = ~clk;

  spi_regs_port i_spi_regs_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .cfgRegs(cfgRegs)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    sdioIn = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] v, bit lsb);
    for (int i = 0; i < 8; i++) sendBit(lsb ? v[i] : v[7-i]);
  endtask

  task automatic bankCheck(string tag);
    int mism = 0, first = -1;
    for (int i = 0; i < 32; i++)
      if (cfgRegs[i*8 +: 8] !== model[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, {first[7:0], 16'h0, cfgRegs[first*8 +: 8]},
               {first[7:0], 16'h0, model[first]});
  endtask

  // Driver: runs one transaction, pushes expected read bytes to the scoreboard
  task automatic xfer(bit rnw, logic [4:0] addr, int nb,
                      logic [31:0] data, string tag);
    bit lsb = model[0][0];
    bit four = model[0][1];
    logic [4:0] a = addr;
    csN = 1'b0; tick(HALF);
    sendByte({rnw, 2'(nb - 1), addr}, lsb);
    for (int k = 0; k < nb; k++) begin
      if (!rnw) begin
        sendByte(data[k*8 +: 8], lsb);
        model[a] = data[k*8 +: 8];
      end else begin
        expQ.push_back(model[a]);
        monLsb = lsb; monFour = four; monTag = tag; monOn = 1'b1;
        sendByte(8'h00, lsb);
      end
      a = lsb ? a + 5'd1 : a - 5'd1;
    end
    monOn = 1'b0;
    tick(HALF); csN = 1'b1; tick(4 * HALF);
  endtask

  // Monitor: captures read bits on the host's sampling edge and scores them
  always @(posedge sclk) begin
    if (monOn) begin
      logic pin;
      pin = monFour ? sdoOut : sdioOut;
      if (monFour ? !(sdoOe && !sdioOe) : !(sdioOe && !sdoOe)) monOeBad = 1'b1;
      if (monLsb) monByte[monCnt] = pin;
      else monByte[7 - monCnt] = pin;
      monCnt++;
      if (monCnt == 8) begin
        logic [7:0] exp;
        exp = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
        check(monByte === exp, {monTag, " R3 read byte"}, monByte, exp);
        check(!monOeBad, {monTag, " R7 pin enables"},
              {sdioOe, sdoOe}, {!monFour, monFour});
        monCnt = 0; monOeBad = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    tick(5); rstN = 1'b1; tick(5);

    // R9 reset state
    check(cfgRegs === '0, "R9 bank zero", cfgRegs[31:0], 0);
    check(!sdioOe && !sdoOe, "R9 enables low", {sdioOe, sdoOe}, 0);

    // R1 R2 R10 single write, MSB first
    xfer(1'b0, 5'd5, 1, 32'h5A, "R1");
    bankCheck("R10 single write");

    // R5 burst write down through the wrap: 1,0,31,30
    xfer(1'b0, 5'd1, 4, 32'h48_33_24_11, "R5");
    bankCheck("R5 down burst wrap");

    // R3 R5 burst read, 3-wire MSB first
    xfer(1'b1, 5'd1, 4, 0, "R5 msb read");
    xfer(1'b1, 5'd5, 1, 0, "R3 single read");

    // R2 register unchanged until its eighth bit
    csN = 1'b0; tick(HALF);
    sendByte({1'b0, 2'd0, 5'd9}, 1'b0);
    for (int i = 0; i < 7; i++) sendBit(8'hA5 >> (7 - i));
    tick(2);
    check(cfgRegs[9*8 +: 8] === model[9], "R2 after seven bits",
          cfgRegs[9*8 +: 8], model[9]);
    sendBit(1'b1); tick(2);
    check(cfgRegs[9*8 +: 8] === 8'hA5, "R2 after eighth bit",
          cfgRegs[9*8 +: 8], 8'hA5);
    model[9] = 8'hA5;
    tick(HALF); csN = 1'b1; tick(4 * HALF);

    // R8 cut-off byte is dropped
    csN = 1'b0; tick(HALF);
    sendByte({1'b0, 2'd0, 5'd7}, 1'b0);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    tick(HALF); csN = 1'b1; tick(4 * HALF);
    bankCheck("R8 abort");

    // R4 bytes past the count are ignored
    csN = 1'b0; tick(HALF);
    sendByte({1'b0, 2'd0, 5'd12}, 1'b0);
    sendByte(8'h3C, 1'b0);
    sendByte(8'hFF, 1'b0);
    sendByte(8'hEE, 1'b0);
    tick(HALF); csN = 1'b1; tick(4 * HALF);
    model[12] = 8'h3C;
    bankCheck("R4 surplus ignored");

    // R6 switch to LSB first (takes effect next transaction)
    xfer(1'b0, 5'd0, 1, 32'h01, "R6");
    bankCheck("R6 mode write");
    xfer(1'b0, 5'd29, 3, 32'h7F_5E_C1, "R6");
    bankCheck("R6 lsb burst up");
    xfer(1'b1, 5'd30, 4, 0, "R6 lsb read wrap");

    // R7 4-wire, LSB first
    xfer(1'b0, 5'd0, 1, 32'h03, "R7");
    xfer(1'b1, 5'd31, 2, 0, "R7 four lsb");
    tick(2);
    check(!sdioOe && !sdoOe, "R7 idle enables", {sdioOe, sdoOe}, 0);

    // R7 4-wire, MSB first
    xfer(1'b0, 5'd0, 1, 32'h02, "R7");
    xfer(1'b1, 5'd5, 2, 0, "R7 four msb");
    bankCheck("R7 bank");

    // back to 3-wire MSB
    xfer(1'b0, 5'd0, 1, 32'h00, "R6");
    xfer(1'b1, 5'd29, 1, 0, "R3 back to msb");
    bankCheck("R10 final bank");

    check(expQ.size() == 0, "R3 all reads seen", expQ.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule